// File: doc/BRIEF.md
# Two-Stage Multiply-Add Cell with Accumulator Input

This block multiplies two small operands and adds two extra terms in one pass: an addend as wide as an operand and a second addend of double width. Both addends go into the same carry-save reduction as the partial products, so a multiply-accumulate costs no more cycles than a plain multiply. Feeding the previous result back into the wide addend gives a running accumulator.

Each operation carries a mode bit that selects unsigned or two's-complement arithmetic. In signed mode the multiplicand, the multiplier and the narrow addend are sign-extended. The wide addend is added as a full-width word. The result is kept modulo two to the double width. A new operation may be issued on every cycle. The result appears with a valid strobe after two clock edges.

Top module: `muladd_mac`

## Requirements
- R1: With signed_mode = 0, out_sum equals (op_a × op_b + add_c + add_w) mod 2^16, with op_a, op_b and add_c zero-extended.
- R2: With signed_mode = 1, op_a, op_b and add_c are two's-complement values sign-extended from bit 7, and out_sum equals (op_a × op_b + add_c + add_w) mod 2^16.
- R3: An operation sampled with in_valid = 1 on a rising edge produces out_valid = 1 and its sum right after the second rising edge that follows. out_valid is low in every other cycle.
- R4: While rst_n is low, out_valid and out_sum are 0, and the reset takes effect without waiting for a clock edge. Operations in flight when reset asserts produce no result.
- R5: out_sum keeps its last result for as long as out_valid is low.
- R6: An operation is accepted on every cycle, with no gap needed between them. Results leave in issue order, and each result uses the signed_mode value given with its own operation.
- R7: A sum that exceeds 16 bits wraps silently. For example, 255 × 255 + 255 + 65535 in unsigned mode gives 0xFEFF.
- R8: Operand values presented while in_valid = 0 produce no output and do not change out_sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle form an operation |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| op_a | input | 8 | Multiplicand |
| op_b | input | 8 | Multiplier |
| add_c | input | 8 | Narrow addend |
| add_w | input | 16 | Wide addend / accumulator input |
| out_valid | output | 1 | out_sum carries a new result |
| out_sum | output | 16 | Result modulo 2^16 |

## Verification
The bench covers the signed extremes: -128 × -128, -128 × 127 and all-ones operands in signed mode. A design with a misplaced or missing correction term for the inverted sign cross-products gets these wrong, and so does one that zero-extends the narrow addend. An all-ones unsigned case checks that the top carry is dropped and not fed back in. Back-to-back issue that alternates the mode from one operation to the next catches a mode bit that is not carried with its own operation. An idle stretch with changing operand values catches a design that reloads its output without a valid operation. A reset taken while an operation is between stages catches a pipeline that leaks a stale result after reset is released.

// File: rtl/muladd_pkg.sv
package muladd_pkg;

  // Interpretation of operand bits for one operation
  typedef enum logic {
    SEL_UNSIGNED = 1'b0,
    SEL_SIGNED   = 1'b1
  } num_mode_e;

endpackage

// File: rtl/muladd_ppgen.sv
// Partial-product and addend row generation.
// Signed products use inverted cross terms plus a fixed correction row.
module muladd_ppgen #(
  parameter  int DW = 8,
  localparam int RW = 2 * DW,
  localparam int NR = DW + 3
) (
  input  logic                   sgn,
  input  logic [DW-1:0]          mcand,
  input  logic [DW-1:0]          mplier,
  input  logic [DW-1:0]          addend_c,
  input  logic [RW-1:0]          addend_w,
  output logic [NR-1:0][RW-1:0]  rows
);

  // Correction for the inverted sign cross terms: ones at column DW and RW-1
  localparam logic [RW-1:0] SIGN_FIX = (RW'(1) << DW) | (RW'(1) << (RW - 1));

  for (genvar i = 0; i < DW; i++) begin : g_row
    logic [DW-1:0] and_bits;
    for (genvar j = 0; j < DW; j++) begin : g_bit
      localparam logic FLIP = ((i == DW - 1) != (j == DW - 1));
      assign and_bits[j] = (mcand[j] & mplier[i]) ^ (sgn & FLIP);
    end
    assign rows[i] = {{DW{1'b0}}, and_bits} << i;
  end

  assign rows[DW]     = sgn ? {{DW{addend_c[DW-1]}}, addend_c} : {{DW{1'b0}}, addend_c};
  assign rows[DW + 1] = addend_w;
  assign rows[DW + 2] = sgn ? SIGN_FIX : '0;

endmodule

// File: rtl/muladd_csa.sv
// Carry-save reduction of all rows into one sum/carry pair.
module muladd_csa #(
  parameter  int DW = 8,
  localparam int RW = 2 * DW,
  localparam int NR = DW + 3
) (
  input  logic [NR-1:0][RW-1:0] rows,
  output logic [RW-1:0]         vec_sum,
  output logic [RW-1:0]         vec_carry
);

  function automatic logic [RW-1:0] fa_sum(input logic [RW-1:0] x,
                                           input logic [RW-1:0] y,
                                           input logic [RW-1:0] z);
    return x ^ y ^ z;
  endfunction

  function automatic logic [RW-1:0] fa_carry(input logic [RW-1:0] x,
                                             input logic [RW-1:0] y,
                                             input logic [RW-1:0] z);
    return ((x & y) | (x & z) | (y & z)) << 1;
  endfunction

  logic [RW-1:0] lvl_s [NR-1];
  logic [RW-1:0] lvl_c [NR-1];

  assign lvl_s[0] = rows[0];
  assign lvl_c[0] = rows[1];

  // One 3:2 compressor level per remaining row
  for (genvar k = 0; k < NR - 2; k++) begin : g_lvl
    assign lvl_s[k+1] = fa_sum  (lvl_s[k], lvl_c[k], rows[k+2]);
    assign lvl_c[k+1] = fa_carry(lvl_s[k], lvl_c[k], rows[k+2]);
  end

  assign vec_sum   = lvl_s[NR-2];
  assign vec_carry = lvl_c[NR-2];

endmodule

// File: rtl/muladd_cpa.sv
// Second stage: carry-propagate add of the redundant pair, output register.
module muladd_cpa #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_valid,
  input  logic [RW-1:0] pair_sum,
  input  logic [RW-1:0] pair_carry,
  output logic          res_valid,
  output logic [RW-1:0] res_sum
);

  function automatic logic [RW-1:0] cpa_add(input logic [RW-1:0] x,
                                            input logic [RW-1:0] y);
    return x + y;
  endfunction

  logic          load_result;
  logic [RW-1:0] resolved;

  assign load_result = pair_valid;
  assign resolved    = cpa_add(pair_sum, pair_carry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_sum   <= '0;
    end else begin
      res_valid <= load_result;
      if (load_result) res_sum <= resolved;
    end
  end

  // R5: no valid result means the output word does not move
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_sum));

endmodule

// File: rtl/muladd_mac.sv
module muladd_mac
  import muladd_pkg::*;
#(
  parameter  int DW = 8,
  localparam int RW = 2 * DW,
  localparam int NR = DW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          signed_mode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] add_c,
  input  logic [RW-1:0] add_w,
  output logic          out_valid,
  output logic [RW-1:0] out_sum
);

  num_mode_e mode_sel;
  logic      sgn_on;

  assign mode_sel = num_mode_e'(signed_mode);
  assign sgn_on   = (mode_sel == SEL_SIGNED);

  // Stage 1: rows and carry-save reduction
  logic [NR-1:0][RW-1:0] pp_rows;
  logic [RW-1:0]         red_sum;
  logic [RW-1:0]         red_carry;

  muladd_ppgen #(.DW(DW)) u_pp (
    .sgn      (sgn_on),
    .mcand    (op_a),
    .mplier   (op_b),
    .addend_c (add_c),
    .addend_w (add_w),
    .rows     (pp_rows)
  );

  muladd_csa #(.DW(DW)) u_csa (
    .rows      (pp_rows),
    .vec_sum   (red_sum),
    .vec_carry (red_carry)
  );

  // Pipeline cut between reduction and carry-propagate add
  logic          s1_valid;
  logic [RW-1:0] s1_sum;
  logic [RW-1:0] s1_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sum   <= '0;
      s1_carry <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sum   <= red_sum;
        s1_carry <= red_carry;
      end
    end
  end

  // Stage 2
  muladd_cpa #(.RW(RW)) u_cpa (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_valid (s1_valid),
    .pair_sum   (s1_sum),
    .pair_carry (s1_carry),
    .res_valid  (out_valid),
    .res_sum    (out_sum)
  );

  // Arithmetic model built from the multiply operator, used by the checks
  function automatic logic [RW-1:0] mac_model(input logic [DW-1:0] a,
                                              input logic [DW-1:0] b,
                                              input logic [DW-1:0] c,
                                              input logic [RW-1:0] w,
                                              input logic          sg);
    logic [RW-1:0] ax, bx, cx, prod;
    ax   = sg ? {{DW{a[DW-1]}}, a} : {{DW{1'b0}}, a};
    bx   = sg ? {{DW{b[DW-1]}}, b} : {{DW{1'b0}}, b};
    cx   = sg ? {{DW{c[DW-1]}}, c} : {{DW{1'b0}}, c};
    prod = ax * bx;
    return prod + cx + w;
  endfunction

  logic [RW-1:0] model_now;
  logic [RW-1:0] s1_pair_total;

  assign model_now     = mac_model(op_a, op_b, add_c, add_w, sgn_on);
  assign s1_pair_total = s1_sum + s1_carry;

  // R1, R2, R7: the registered redundant pair resolves to the modular result
  p_pair_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (s1_pair_total == $past(model_now)));

  // R3: a result strobe is always backed by an issue two edges earlier
  p_valid_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R3, R6: every issue outside reset yields its strobe
  p_issue_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid, 2) && $past(rst_n, 2) && $past(rst_n)) |-> out_valid);

endmodule

// File: tb/muladd_mac_test.sv
module muladd_mac_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        signed_mode = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [7:0]  add_c = '0;
  logic [15:0] add_w = '0;
  logic        out_valid;
  logic [15:0] out_sum;

  always #5 clk = ~clk;

  muladd_mac #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .add_c(add_c), .add_w(add_w),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit seen   = 1'b0;
  logic [15:0] last_sum = '0;

  logic [15:0] q_val[$];
  int          q_due[$];
  string       q_tag[$];

  logic [15:0] m_exp;
  int          m_due;
  string       m_tag;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Expected value from signed integer arithmetic (R1, R2, R7)
  function automatic logic [15:0] expect_val(input logic [7:0] a, input logic [7:0] b,
                                             input logic [7:0] c, input logic [15:0] w,
                                             input bit sg);
    int ai, bi, ci, r;
    ai = int'(a); bi = int'(b); ci = int'(c);
    if (sg && a[7]) ai = ai - 256;
    if (sg && b[7]) bi = bi - 256;
    if (sg && c[7]) ci = ci - 256;
    r = ai * bi + ci + int'(w);
    return r[15:0];
  endfunction

  // Driver: issue one operation and push its expectation
  task automatic issue(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [15:0] w, input bit sg, input string tag);
    @(negedge clk);
    in_valid = 1'b1; signed_mode = sg;
    op_a = a; op_b = b; add_c = c; add_w = w;
    q_val.push_back(expect_val(a, b, c, w, sg));
    q_due.push_back(cyc + 2);
    q_tag.push_back(tag);
  endtask

  // R8: idle cycles with changing operand values
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      signed_mode = 1'($urandom);
      op_a = 8'($urandom); op_b = 8'($urandom);
      add_c = 8'($urandom); add_w = 16'($urandom);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_val.size() == 0) begin
          check(1'b0, "R8", out_sum, 16'h0, "result with nothing issued");
        end else begin
          m_exp = q_val.pop_front();
          m_due = q_due.pop_front();
          m_tag = q_tag.pop_front();
          check(out_sum == m_exp, m_tag, out_sum, m_exp, "sum");
          check(cyc == m_due, "R3", cyc[15:0], m_due[15:0], "latency cycle");
        end
        last_sum = out_sum;
        seen = 1'b1;
      end else if (seen) begin
        check(out_sum == last_sum, "R5", out_sum, last_sum, "hold while idle");
      end
    end
  end

  initial begin
    // R4: reset state with garbage operands and in_valid high
    in_valid = 1'b1; op_a = 8'hA5; op_b = 8'h5A; add_c = 8'h33; add_w = 16'hBEEF;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R4", 16'(out_valid), 16'h0, "valid in reset");
    check(out_sum == 16'h0, "R4", out_sum, 16'h0, "sum in reset");
    rst_n = 1'b1; in_valid = 1'b0;
    idle(2);

    // Directed unsigned and signed cases
    issue(8'd0,   8'd0,   8'd0,   16'd0,    1'b0, "R1");
    issue(8'd12,  8'd10,  8'd7,   16'd1000, 1'b0, "R1");
    issue(8'hFF,  8'hFF,  8'hFF,  16'hFFFF, 1'b0, "R7");   // expect 0xFEFF
    issue(8'h80,  8'h80,  8'h80,  16'h0000, 1'b1, "R2");   // 16384 - 128
    issue(8'h80,  8'h7F,  8'h00,  16'h0000, 1'b1, "R2");   // -16256
    issue(8'hFF,  8'hFF,  8'hFF,  16'hFFFF, 1'b1, "R2");   // 1 - 1 - 1
    issue(8'h7F,  8'h7F,  8'h7F,  16'h7FFF, 1'b1, "R7");
    issue(8'hFF,  8'h01,  8'h80,  16'h8000, 1'b1, "R2");
    idle(4);

    // R6: back-to-back, mode alternating per operation
    for (int i = 0; i < 300; i++) begin
      issue(8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 1'(i % 2), "R6");
    end
    idle(5);

    // Accumulate chain: feed a known running total through add_w
    begin
      logic [15:0] acc;
      acc = 16'h0000;
      for (int i = 0; i < 6; i++) begin
        issue(8'(i + 3), 8'hF0, 8'h01, acc, 1'b1, "R2");
        acc = expect_val(8'(i + 3), 8'hF0, 8'h01, acc, 1'b1);
      end
    end
    idle(4);

    // R4: reset while an operation is in flight
    issue(8'd3, 8'd4, 8'd5, 16'd6, 1'b0, "R4");
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    q_val.delete(); q_due.delete(); q_tag.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R4", 16'(out_valid), 16'h0, "valid after mid reset");
    check(out_sum == 16'h0, "R4", out_sum, 16'h0, "sum after mid reset");
    last_sum = 16'h0;
    rst_n = 1'b1;
    idle(4);   // in-flight operation must not appear

    issue(8'd9, 8'd9, 8'd9, 16'd9, 1'b0, "R1");
    issue(8'h81, 8'h02, 8'hFE, 16'd100, 1'b1, "R2");
    idle(5);

    check(q_val.size() == 0, "R3", 16'(q_val.size()), 16'h0, "results outstanding");
    done = 1'b1;
    summary();
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", cyc, 0);
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule